// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

A general-purpose I/O port with a parameterised number of lines (16 by default), controlled over a simple word-addressed register bus. The bus has one write strobe and a read path that is always active. Each line is set as an input or an output. Output lines drive the stored output data, and an output-enable signal goes to the pads. Input lines are sampled on every clock. Each line can raise a sticky interrupt on either a rising or a falling edge, chosen by a polarity bit for that line.

Software writes the direction, polarity, mask and pin-enable registers. It reads the gated input data and the status register. It acknowledges interrupts by writing ones to the status register. A single registered interrupt output stays high while any status bit is set.

The register offsets are byte addresses on a word grid:

| Offset | Register | Access |
|---|---|---|
| 0x00 | input data | read only |
| 0x04 | output data | read/write |
| 0x08 | direction | read/write |
| 0x0C | polarity | read/write |
| 0x10 | mask | read/write |
| 0x14 | status | write one to clear |
| 0x18 | pin enable | read/write |

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the registers read as follows: input data 0, output data all ones, direction all ones, polarity all ones, mask all ones, status 0 and pin enable all ones. The interrupt output reads 0.
- R2: pad_oe_o bit n is 1 exactly when direction bit n is 0 (1 = input, 0 = output). pad_o always equals the stored output data, so a line switched to output drives its stored value in the cycle after the direction write.
- R3: With polarity bit 1 (rising) a low-to-high change on pins_i sets that line's status bit. With polarity bit 0 (falling) a high-to-low change sets it. The change is seen between two consecutive clocks, and the status bit is set on the clock where the new level is sampled. A line sets status only if its direction bit is 1 and its mask bit is 0.
- R4: A write to offset 0x14 clears every status bit written as 1 and leaves the bits written as 0 unchanged.
- R5: If an edge and a clear write hit the same status bit on the same clock, the bit ends up set.
- R6: irq_o is registered. It goes high one clock after any status bit is set, and it goes low one clock after the status register becomes all zero.
- R7: A read of offset 0x00 returns the sampled inputs ANDed with the pin-enable register.
- R8: Writes to offset 0x00 and to unmapped offsets change no register. Reads of unmapped offsets return 0.
- R9: Output data, direction, polarity, mask and pin enable read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | N_LINES | Write data |
| bus_rdata_o | output | N_LINES | Read data for bus_addr_i, combinational |
| pins_i | input | N_LINES | Synchronous input pin levels |
| pad_o | output | N_LINES | Output data toward the pads |
| pad_oe_o | output | N_LINES | Per-line output enable |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The assertions check the following properties on every cycle:
- A status bit never becomes set on an output line or a masked line.
- A status bit never falls unless a clear write covered it.
- The interrupt output rises only after the status register was non-zero.
- The gated input read never shows a bit whose pin enable is off.

The bench's scenarios show the rest:
- The exact status value chosen by polarity.
- A clear and an edge colliding on the same bit.
- The reset values.
- That writes to the read-only and unmapped offsets are ignored.
- The one-clock latency of the interrupt output.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_IN   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_POL  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PEN  = 8'h18;
endpackage

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [N_LINES-1:0] bus_wdata_i,
  input  logic [N_LINES-1:0] in_q_i,
  input  logic [N_LINES-1:0] status_i,
  output logic [N_LINES-1:0] out_q_o,
  output logic [N_LINES-1:0] dir_q_o,
  output logic [N_LINES-1:0] pol_q_o,
  output logic [N_LINES-1:0] mask_q_o,
  output logic [N_LINES-1:0] clr_o,
  output logic [N_LINES-1:0] rdata_o
);
  logic [N_LINES-1:0] pen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o  <= '1;
      dir_q_o  <= '1;
      pol_q_o  <= '1;
      mask_q_o <= '1;
      pen_q    <= '1;
    end else if (bus_we_i) begin
      unique case (bus_addr_i)
        OFS_OUT:  out_q_o  <= bus_wdata_i;
        OFS_DIR:  dir_q_o  <= bus_wdata_i;
        OFS_POL:  pol_q_o  <= bus_wdata_i;
        OFS_MASK: mask_q_o <= bus_wdata_i;
        OFS_PEN:  pen_q    <= bus_wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr_o = (bus_we_i && bus_addr_i == OFS_STAT) ? bus_wdata_i : '0;

  always_comb begin
    unique case (bus_addr_i)
      OFS_IN:   rdata_o = in_q_i & pen_q;
      OFS_OUT:  rdata_o = out_q_o;
      OFS_DIR:  rdata_o = dir_q_o;
      OFS_POL:  rdata_o = pol_q_o;
      OFS_MASK: rdata_o = mask_q_o;
      OFS_STAT: rdata_o = status_i;
      OFS_PEN:  rdata_o = pen_q;
      default:  rdata_o = '0;
    endcase
  end

  always_comb begin
    if (rst_ni && bus_addr_i == OFS_IN)
      AST_IN_GATED: assert ((rdata_o & ~pen_q) == '0); // R7
  end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned N_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] pins_i,
  input  logic [N_LINES-1:0] dir_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] in_q_o,
  output logic [N_LINES-1:0] status_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] hit;
  logic [N_LINES-1:0] set_bits;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    // polarity 1 = rising, 0 = falling
    assign hit[g] = pol_i[g] ? (pins_i[g] & ~in_q_o[g]) : (~pins_i[g] & in_q_o[g]);
  end

  assign set_bits = hit & dir_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q_o   <= '0;
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      in_q_o   <= pins_i;
      // set wins over a clear on the same bit
      status_o <= (status_o & ~clr_i) | set_bits;
      irq_o    <= |status_o;
    end
  end

  AST_NO_SET_ON_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(dir_i)) == '0)); // R3
  AST_NO_SET_WHEN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & $past(mask_i)) == '0)); // R3
  AST_FALL_ONLY_BY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o) & ~status_o & ~$past(clr_i)) == '0)); // R4
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [N_LINES-1:0] bus_wdata_i,
  output logic [N_LINES-1:0] bus_rdata_o,
  input  logic [N_LINES-1:0] pins_i,
  output logic [N_LINES-1:0] pad_o,
  output logic [N_LINES-1:0] pad_oe_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] in_q, status, out_q, dir_q, pol_q, mask_q, clr;

  gpio_edge_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .in_q_i      (in_q),
    .status_i    (status),
    .out_q_o     (out_q),
    .dir_q_o     (dir_q),
    .pol_q_o     (pol_q),
    .mask_q_o    (mask_q),
    .clr_o       (clr),
    .rdata_o     (bus_rdata_o)
  );

  gpio_edge_detect #(.N_LINES(N_LINES)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (pins_i),
    .dir_i    (dir_q),
    .pol_i    (pol_q),
    .mask_i   (mask_q),
    .clr_i    (clr),
    .in_q_o   (in_q),
    .status_o (status),
    .irq_o    (irq_o)
  );

  assign pad_o    = out_q;
  assign pad_oe_o = ~dir_q;

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(status != '0)); // R6
endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pad, pad_oe;
  logic         irq;

  int checks = 0;
  int fails = 0;

  logic [N-1:0] m_in, m_out, m_dir, m_pol, m_mask, m_st, m_pen;
  logic         m_irq;

  always #2 clk = ~clk;

  gpio_edge_port #(.N_LINES(N)) u_gpio_edge_port (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pins_i(pins),
    .pad_o(pad), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  function automatic logic [N-1:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return m_in & m_pen;
      8'h04: return m_out;
      8'h08: return m_dir;
      8'h0C: return m_pol;
      8'h10: return m_mask;
      8'h14: return m_st;
      8'h18: return m_pen;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R7";
      8'h14: return "R4";
      8'h04, 8'h08, 8'h0C, 8'h10, 8'h18: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_in = '0; m_out = '1; m_dir = '1; m_pol = '1; m_mask = '1;
    m_st = '0; m_pen = '1; m_irq = 1'b0;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic cycle(string tag, logic [N-1:0] p, logic w, logic [7:0] a, logic [N-1:0] d);
    logic [N-1:0] hit, clr;
    pins = p; we = w; addr = a; wdata = d;
    #1;
    chk(tag, "read", rdata, model_read(a));
    @(posedge clk);
    for (int i = 0; i < N; i++)
      hit[i] = m_pol[i] ? (p[i] & ~m_in[i]) : (~p[i] & m_in[i]);
    clr = (w && a == 8'h14) ? d : '0;
    m_irq = |m_st;
    m_st = (m_st & ~clr) | (hit & m_dir & ~m_mask);
    m_in = p;
    if (w) begin
      case (a)
        8'h04: m_out = d;
        8'h08: m_dir = d;
        8'h0C: m_pol = d;
        8'h10: m_mask = d;
        8'h18: m_pen = d;
        default: ;
      endcase
    end
    @(negedge clk);
    we = 1'b0;
    chk("R6", "irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
    chk("R2", "pad", pad, m_out);
    chk("R2", "pad_oe", pad_oe, ~m_dir);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int k = 0; k < 8; k++) cycle("R1", '0, 1'b0, 8'(k * 4), '0);
    chk("R1", "irq after reset", {{(N-1){1'b0}}, irq}, '0);

    // R9 readback, R2 direction switch drives stored data
    cycle("R9", '0, 1'b1, 8'h04, 16'h1234);
    cycle("R9", '0, 1'b0, 8'h04, '0);
    cycle("R2", '0, 1'b1, 8'h08, 16'hFF00);
    cycle("R9", '0, 1'b0, 8'h08, '0);

    // R3 polarity: low byte rising, high byte falling, all inputs unmasked
    cycle("R3", '0, 1'b1, 8'h08, 16'hFFFF);
    cycle("R3", '0, 1'b1, 8'h0C, 16'h00FF);
    cycle("R3", '0, 1'b1, 8'h10, 16'h0000);
    cycle("R3", 16'hFFFF, 1'b0, 8'h14, '0);
    cycle("R3", 16'hFFFF, 1'b0, 8'h14, '0);
    cycle("R6", 16'h0000, 1'b0, 8'h14, '0);
    cycle("R3", 16'h0000, 1'b0, 8'h14, '0);
    // R4 partial clear
    cycle("R4", '0, 1'b1, 8'h14, 16'h0F0F);
    cycle("R4", '0, 1'b0, 8'h14, '0);
    // R5 clear and edge collide on bit 0
    cycle("R5", 16'h0001, 1'b1, 8'h14, 16'hFFFF);
    cycle("R5", 16'h0001, 1'b0, 8'h14, '0);
    cycle("R6", 16'h0001, 1'b1, 8'h14, 16'hFFFF);
    cycle("R6", 16'h0001, 1'b0, 8'h14, '0);
    cycle("R6", 16'h0001, 1'b0, 8'h14, '0);
    // R3 masked and output lines do not set
    cycle("R3", 16'h0001, 1'b1, 8'h10, 16'h00F0);
    cycle("R3", 16'h0001, 1'b1, 8'h08, 16'hFF0F);
    cycle("R3", 16'h00FE, 1'b0, 8'h14, '0);
    cycle("R3", 16'h00FE, 1'b0, 8'h14, '0);
    // R7 pin-enable gating
    cycle("R7", 16'hFFFF, 1'b1, 8'h18, 16'h0F0F);
    cycle("R7", 16'hFFFF, 1'b0, 8'h00, '0);
    // R8 ignored writes and zero reads
    cycle("R8", 16'hFFFF, 1'b1, 8'h00, 16'h0000);
    cycle("R8", 16'hFFFF, 1'b1, 8'h1C, 16'h0000);
    cycle("R8", 16'hFFFF, 1'b1, 8'h06, 16'h0000);
    for (int k = 0; k < 8; k++) cycle("R8", 16'hFFFF, 1'b0, 8'(k * 4), '0);
    cycle("R8", 16'hFFFF, 1'b0, 8'hFC, '0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic       w;
      int r;
      r = $urandom % 10;
      a = (r < 8) ? 8'(r * 4) : 8'($urandom % 256);
      w = ($urandom % 4) == 0;
      cycle(tag_of(a), pins ^ (N'($urandom) & N'($urandom) & N'($urandom)), w, a, N'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule